// File: doc/BRIEF.md
# Single-Cycle Integer Core

This block is a 32-bit integer processor that retires exactly one instruction on every clock edge. It holds one word-organized memory that serves both instruction fetch and data loads and stores. It holds a 32-entry register file and a program counter. Ten operations are supported: five register-register ALU operations, an add-immediate, a word load, a word store, a branch on equality and an absolute jump. A dedicated all-ones word stops the core.

Software is placed in memory through a preload port, which only works while reset is asserted. After reset is released the core runs from address zero. It runs until it either retires a halt word or meets an illegal condition. An illegal condition is a misaligned or out-of-range memory access, a fetch outside memory, or an unknown encoding. An illegal condition freezes the core with a sticky fault flag and a cause code. The program counter and any register can be observed at all times.

Top module: `sc_core`

## Requirements
- R1: While rst_ni is low, pc_o is 0, halted_o and fault_o are 0, fault_cause_o is 0 and every register reads 0. Preload writes (load_en_i, word index load_addr_i) take effect only while rst_ni is low and are ignored while the core runs.
- R2: The R-type format has opcode bits [31:26] = 0, rs in [25:21], rt in [20:16], rd in [15:11] and funct in [5:0]. The funct codes are 0x20 add, 0x22 sub, 0x24 and, 0x25 or and 0x2A slt. Each writes its result to rd. add and sub wrap modulo 2^32, and slt writes 1 when rs < rt as signed values and 0 otherwise.
- R3: Register 0 always reads 0, and any write aimed at it is discarded.
- R4: addi (opcode 0x08) writes rs plus the sign-extended 16-bit immediate [15:0] to rt, wrapping modulo 2^32.
- R5: lw (0x23) and sw (0x2B) use the address rs + sign-extended offset. lw loads the 32-bit word at that address into rt. sw stores rt there, and a later lw of the same address returns it.
- R6: beq (0x04) moves to PC+4+(sign-extended offset<<2) when rs equals rt, and to PC+4 otherwise.
- R7: j (0x02) moves to {PC+4[31:28], index[25:0], 2'b00}.
- R8: The word 0xFFFFFFFF retires as halt. halted_o rises after that edge and stays high, pc_o keeps the address of the halt word, and no register changes afterwards.
- R9: A load or store whose address has bit 1 or bit 0 set changes no register or memory word. It sets fault_o with fault_cause_o = 1 and freezes pc_o at that instruction.
- R10: A load or store whose address is MEM_WORDS*4 or above, and any fetch from such a PC, sets fault_o with fault_cause_o = 2 and changes no state.
- R11: Any other opcode, or an R-type funct outside the five listed, sets fault_o with fault_cause_o = 3 and changes no state. halted_o and fault_o are never both high.
- R12: A program that executes N instructions, including the final halt or faulting word, raises halted_o or fault_o after exactly N clock edges following reset release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset; also enables preload |
| load_en_i | input | 1 | Preload write strobe |
| load_addr_i | input | AW (10) | Preload word index |
| load_data_i | input | 32 | Preload word |
| dbg_addr_i | input | 5 | Register read-back select |
| dbg_data_o | output | 32 | Register read-back value |
| pc_o | output | 32 | Current program counter |
| halted_o | output | 1 | Halt retired |
| fault_o | output | 1 | Sticky fault |
| fault_cause_o | output | 2 | 0 none, 1 misaligned, 2 out of range, 3 illegal |

## Verification
The assertions assume that preload writes happen only under reset and that the program counter starts word-aligned. Every program the bench builds loads all memory words while reset is held, so the data side never reads contents left over from the previous run. Random programs keep stores and loads at aligned addresses inside the upper half of memory, and keep branches forward within the halt pad. This confines random runs to legal behaviour, and directed programs reach the fault causes one at a time.

// File: rtl/sc_core_pkg.sv
package sc_core_pkg;
  localparam logic [5:0] OPC_RTYPE = 6'h00;
  localparam logic [5:0] OPC_ADDI  = 6'h08;
  localparam logic [5:0] OPC_LW    = 6'h23;
  localparam logic [5:0] OPC_SW    = 6'h2B;
  localparam logic [5:0] OPC_BEQ   = 6'h04;
  localparam logic [5:0] OPC_J     = 6'h02;
  localparam logic [5:0] FN_ADD = 6'h20;
  localparam logic [5:0] FN_SUB = 6'h22;
  localparam logic [5:0] FN_AND = 6'h24;
  localparam logic [5:0] FN_OR  = 6'h25;
  localparam logic [5:0] FN_SLT = 6'h2A;

  typedef enum logic [1:0] {FLT_NONE, FLT_MISALIGN, FLT_RANGE, FLT_ILLEGAL} fault_e;
  typedef enum logic [2:0] {ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_SLT} alu_op_e;

  typedef struct packed {
    alu_op_e alu_op;
    logic    rf_we;
    logic    dst_rt;
    logic    imm_b;
    logic    mem_rd;
    logic    mem_wr;
    logic    branch;
    logic    jump;
    logic    halt;
    logic    illegal;
  } ctrl_t;
endpackage

// File: rtl/sc_decode.sv
module sc_decode
  import sc_core_pkg::*;
(
  input  logic [31:0] instr_i,
  output ctrl_t       ctrl_o
);
  always_comb begin
    ctrl_o = '0;
    ctrl_o.alu_op = ALU_ADD;
    if (instr_i == '1) begin
      ctrl_o.halt = 1'b1;
    end else begin
      case (instr_i[31:26])
        OPC_RTYPE: begin
          ctrl_o.rf_we = 1'b1;
          case (instr_i[5:0])
            FN_ADD:  ctrl_o.alu_op = ALU_ADD;
            FN_SUB:  ctrl_o.alu_op = ALU_SUB;
            FN_AND:  ctrl_o.alu_op = ALU_AND;
            FN_OR:   ctrl_o.alu_op = ALU_OR;
            FN_SLT:  ctrl_o.alu_op = ALU_SLT;
            default: begin
              ctrl_o.rf_we   = 1'b0;
              ctrl_o.illegal = 1'b1;
            end
          endcase
        end
        OPC_ADDI: begin ctrl_o.rf_we = 1'b1; ctrl_o.dst_rt = 1'b1; ctrl_o.imm_b = 1'b1; end
        OPC_LW: begin
          ctrl_o.rf_we = 1'b1; ctrl_o.dst_rt = 1'b1; ctrl_o.imm_b = 1'b1; ctrl_o.mem_rd = 1'b1;
        end
        OPC_SW:  begin ctrl_o.imm_b = 1'b1; ctrl_o.mem_wr = 1'b1; end
        OPC_BEQ: ctrl_o.branch = 1'b1;
        OPC_J:   ctrl_o.jump = 1'b1;
        default: ctrl_o.illegal = 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/sc_alu.sv
module sc_alu
  import sc_core_pkg::*;
#(
  parameter int W = 32
) (
  input  alu_op_e      op_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] y_o
);
  always_comb begin
    case (op_i)
      ALU_ADD: y_o = a_i + b_i;
      ALU_SUB: y_o = a_i - b_i;
      ALU_AND: y_o = a_i & b_i;
      ALU_OR:  y_o = a_i | b_i;
      ALU_SLT: y_o = {{(W-1){1'b0}}, $signed(a_i) < $signed(b_i)};
      default: y_o = '0;
    endcase
  end
endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
  parameter int W    = 32,
  parameter int NREG = 32,
  localparam int RA  = $clog2(NREG)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [RA-1:0] ra_a_i,
  input  logic [RA-1:0] ra_b_i,
  input  logic [RA-1:0] ra_dbg_i,
  output logic [W-1:0]  rd_a_o,
  output logic [W-1:0]  rd_b_o,
  output logic [W-1:0]  rd_dbg_o,
  input  logic          we_i,
  input  logic [RA-1:0] wa_i,
  input  logic [W-1:0]  wd_i
);
  logic [W-1:0] rf_q [NREG];

  // entry 0 has no write path
  for (genvar g = 0; g < NREG; g++) begin : g_reg
    if (g == 0) begin : g_zero
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) rf_q[g] <= '0;
        else         rf_q[g] <= '0;
    end else begin : g_live
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni)                            rf_q[g] <= '0;
        else if (we_i && wa_i == RA'(g))        rf_q[g] <= wd_i;
    end
  end

  assign rd_a_o   = rf_q[ra_a_i];
  assign rd_b_o   = rf_q[ra_b_i];
  assign rd_dbg_o = rf_q[ra_dbg_i];

  p_r0_no_write_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |-> wa_i != '0);
endmodule

// File: rtl/sc_core.sv
module sc_core
  import sc_core_pkg::*;
#(
  parameter int MEM_WORDS = 1024,
  localparam int AW = $clog2(MEM_WORDS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_en_i,
  input  logic [AW-1:0] load_addr_i,
  input  logic [31:0]   load_data_i,
  input  logic [4:0]    dbg_addr_i,
  output logic [31:0]   dbg_data_o,
  output logic [31:0]   pc_o,
  output logic          halted_o,
  output logic          fault_o,
  output logic [1:0]    fault_cause_o
);
  localparam logic [29:0] LIMIT = 30'(MEM_WORDS);

  logic [31:0] mem_q [MEM_WORDS];
  logic [31:0] pc_q, pc_d, pc_plus4, instr;
  logic        halted_q, fault_q;
  fault_e      cause_q, cause_d;
  ctrl_t       ctrl;
  logic [31:0] rs_val, rt_val, imm_sx, alu_b, alu_y, wdata;
  logic [4:0]  dst;
  logic        run, exec_ok, acc, rf_we, mem_we;
  logic [AW-1:0] didx;

  assign instr    = mem_q[pc_q[AW+1:2]];
  assign pc_plus4 = pc_q + 32'd4;
  assign imm_sx   = {{16{instr[15]}}, instr[15:0]};

  sc_decode u_dec (.instr_i(instr), .ctrl_o(ctrl));

  assign dst = ctrl.dst_rt ? instr[20:16] : instr[15:11];

  sc_regfile #(.W(32), .NREG(32)) u_rf (
    .clk_i, .rst_ni,
    .ra_a_i(instr[25:21]), .ra_b_i(instr[20:16]), .ra_dbg_i(dbg_addr_i),
    .rd_a_o(rs_val), .rd_b_o(rt_val), .rd_dbg_o(dbg_data_o),
    .we_i(rf_we), .wa_i(dst), .wd_i(wdata)
  );

  assign alu_b = ctrl.imm_b ? imm_sx : rt_val;
  sc_alu #(.W(32)) u_alu (.op_i(ctrl.alu_op), .a_i(rs_val), .b_i(alu_b), .y_o(alu_y));

  assign acc  = ctrl.mem_rd | ctrl.mem_wr;
  assign didx = alu_y[AW+1:2];

  always_comb begin
    cause_d = FLT_NONE;
    if (pc_q[31:2] >= LIMIT)             cause_d = FLT_RANGE;
    else if (|pc_q[1:0])                 cause_d = FLT_MISALIGN;
    else if (ctrl.illegal)               cause_d = FLT_ILLEGAL;
    else if (acc && |alu_y[1:0])         cause_d = FLT_MISALIGN;
    else if (acc && alu_y[31:2] >= LIMIT) cause_d = FLT_RANGE;
  end

  assign run     = !halted_q && !fault_q;
  assign exec_ok = run && cause_d == FLT_NONE && !ctrl.halt;
  assign rf_we   = exec_ok && ctrl.rf_we && dst != 5'd0;
  assign mem_we  = exec_ok && ctrl.mem_wr;
  assign wdata   = ctrl.mem_rd ? mem_q[didx] : alu_y;

  always_comb begin
    pc_d = pc_plus4;
    if (ctrl.branch && rs_val == rt_val) pc_d = pc_plus4 + {imm_sx[29:0], 2'b00};
    else if (ctrl.jump)                  pc_d = {pc_plus4[31:28], instr[25:0], 2'b00};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q     <= '0;
      halted_q <= 1'b0;
      fault_q  <= 1'b0;
      cause_q  <= FLT_NONE;
    end else if (run) begin
      if (cause_d != FLT_NONE) begin
        fault_q <= 1'b1;
        cause_q <= cause_d;
      end else if (ctrl.halt) begin
        halted_q <= 1'b1;
      end else begin
        pc_q <= pc_d;
      end
    end
  end

  // preload only under reset; stores only while running
  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      if (load_en_i) mem_q[load_addr_i] <= load_data_i;
    end else if (mem_we) begin
      mem_q[didx] <= rt_val;
    end
  end

  assign pc_o          = pc_q;
  assign halted_o      = halted_q;
  assign fault_o       = fault_q;
  assign fault_cause_o = cause_q;

  p_halt_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_o |=> halted_o);
  p_pc_frozen_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (halted_o || fault_o) |=> $stable(pc_o));
  p_fault_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |=> fault_o && $stable(fault_cause_o));
  p_pc_word_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_o[1:0] == 2'b00);
  p_stop_excl_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(halted_o && fault_o));
  p_store_in_range_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we |-> (alu_y[31:2] < LIMIT && alu_y[1:0] == 2'b00));
  p_no_write_stopped_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (halted_o || fault_o) |-> !(rf_we || mem_we));
endmodule

// File: tb/test_sc_core.sv
module test_sc_core;
  localparam int MW = 1024;
  localparam logic [31:0] HALT = 32'hFFFF_FFFF;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        load_en = 1'b0;
  logic [9:0]  load_addr = '0;
  logic [31:0] load_data = '0;
  logic [4:0]  dbg_addr = '0;
  logic [31:0] dbg_data, pc;
  logic        halted, fault;
  logic [1:0]  cause;

  always #5 clk = ~clk;

  sc_core #(.MEM_WORDS(MW)) i_sc_core (
    .clk_i(clk), .rst_ni(rst_n), .load_en_i(load_en), .load_addr_i(load_addr),
    .load_data_i(load_data), .dbg_addr_i(dbg_addr), .dbg_data_o(dbg_data),
    .pc_o(pc), .halted_o(halted), .fault_o(fault), .fault_cause_o(cause)
  );

  int n_chk = 0, n_fail = 0, cyc_total = 0;
  logic [31:0] b_mem [MW];
  logic [31:0] m_reg [32];
  logic [31:0] e_pc;
  logic        e_halt, e_fault;
  logic [1:0]  e_cause;
  int          e_cyc;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] enc_r(int rs, int rt, int rd, int fn);
    return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'd0, 6'(fn)};
  endfunction
  function automatic logic [31:0] enc_i(int op, int rs, int rt, int imm);
    return {6'(op), 5'(rs), 5'(rt), 16'(imm)};
  endfunction
  function automatic logic [31:0] enc_j(int idx);
    return {6'h02, 26'(idx)};
  endfunction

  task automatic clear_prog();
    for (int i = 0; i < MW; i++) b_mem[i] = 32'h0;
  endtask

  // reference interpretation of the requirements
  task automatic model_run();
    logic [31:0] p, w, va, vb, imm, a, nxt;
    logic [4:0] rs, rt, rd;
    logic [31:0] mm [MW];
    for (int i = 0; i < MW; i++) mm[i] = b_mem[i];
    for (int i = 0; i < 32; i++) m_reg[i] = '0;
    p = 0; e_halt = 0; e_fault = 0; e_cause = 0; e_cyc = 0;
    while (e_cyc < 5000) begin
      e_cyc++;
      if (p[31:2] >= MW) begin e_fault = 1; e_cause = 2; break; end
      w = mm[p[11:2]];
      if (w == HALT) begin e_halt = 1; break; end
      rs = w[25:21]; rt = w[20:16]; rd = w[15:11];
      va = m_reg[rs]; vb = m_reg[rt]; imm = {{16{w[15]}}, w[15:0]}; nxt = p + 4;
      case (w[31:26])
        6'h00: begin
          case (w[5:0])
            6'h20: a = va + vb;
            6'h22: a = va - vb;
            6'h24: a = va & vb;
            6'h25: a = va | vb;
            6'h2A: a = ($signed(va) < $signed(vb)) ? 32'd1 : 32'd0;
            default: begin e_fault = 1; e_cause = 3; end
          endcase
          if (e_fault) break;
          if (rd != 0) m_reg[rd] = a;
        end
        6'h08: if (rt != 0) m_reg[rt] = va + imm;
        6'h23, 6'h2B: begin
          a = va + imm;
          if (a[1:0] != 0) begin e_fault = 1; e_cause = 1; break; end
          if (a[31:2] >= MW) begin e_fault = 1; e_cause = 2; break; end
          if (w[31:26] == 6'h23) begin if (rt != 0) m_reg[rt] = mm[a[11:2]]; end
          else mm[a[11:2]] = vb;
        end
        6'h04: if (va == vb) nxt = p + 4 + (imm << 2);
        6'h02: nxt = {nxt[31:28], w[25:0], 2'b00};
        default: begin e_fault = 1; e_cause = 3; break; end
      endcase
      p = nxt;
    end
    e_pc = p;
  endtask

  task automatic rd_reg(int r, output logic [31:0] v);
    dbg_addr = 5'(r);
    #1 v = dbg_data;
  endtask

  task automatic preload();
    rst_n = 1'b0;
    for (int i = 0; i < MW; i++) begin
      @(negedge clk);
      load_en = 1'b1; load_addr = 10'(i); load_data = b_mem[i];
    end
    @(negedge clk);
    load_en = 1'b0;
  endtask

  task automatic run_prog(string tag);
    int cyc;
    int bad;
    logic [31:0] v;
    model_run();
    preload();
    rst_n = 1'b1;
    cyc = 0;
    while (cyc < 5100) begin
      @(posedge clk); cyc++;
      @(negedge clk);
      if (halted || fault) break;
    end
    chk({tag, " R8 halted"}, 32'(halted), 32'(e_halt));
    chk({tag, " R11 fault"}, 32'(fault), 32'(e_fault));
    chk({tag, " R9/R10/R11 cause"}, 32'(cause), 32'(e_cause));
    chk({tag, " R6 pc"}, pc, e_pc);
    chk({tag, " R12 cycles"}, 32'(cyc), 32'(e_cyc));
    bad = 0;
    for (int r = 0; r < 32; r++) begin
      rd_reg(r, v);
      if (v !== m_reg[r]) begin
        if (bad == 0) $display("FAIL %s R2 reg %0d actual=%h expected=%h", tag, r, v, m_reg[r]);
        bad++;
      end
    end
    n_chk++;
    if (bad != 0) n_fail++;
  endtask

  task automatic reg_is(string tag, int r, logic [31:0] exp);
    logic [31:0] v;
    rd_reg(r, v);
    chk(tag, v, exp);
  endtask

  initial begin : watchdog
    forever begin
      @(posedge clk);
      cyc_total++;
      if (cyc_total > 150000) begin
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=%0d expected<150000", cyc_total);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
      end
    end
  end

  initial begin : stim
    logic [31:0] v;
    void'($urandom(32'd7151));

    // R1 reset state, then R2 R3 R4 arithmetic
    clear_prog();
    b_mem[0] = enc_i(8, 0, 1, -1);
    b_mem[1] = enc_i(8, 0, 2, 5);
    b_mem[2] = enc_r(1, 2, 3, 'h2A);
    b_mem[3] = enc_r(2, 1, 4, 'h2A);
    b_mem[4] = enc_r(2, 1, 5, 'h22);
    b_mem[5] = enc_r(1, 2, 6, 'h20);
    b_mem[6] = enc_r(1, 2, 7, 'h24);
    b_mem[7] = enc_r(2, 0, 8, 'h25);
    b_mem[8] = enc_i(8, 0, 0, 9);
    b_mem[9] = enc_r(2, 2, 0, 'h20);
    b_mem[10] = enc_i(8, 1, 9, 16'h8000);
    b_mem[11] = HALT;
    preload();
    chk("R1 reset pc", pc, 0);
    chk("R1 reset halted", 32'(halted), 0);
    chk("R1 reset fault", 32'(fault), 0);
    chk("R1 reset cause", 32'(cause), 0);
    run_prog("arith");
    reg_is("R2 slt signed true", 3, 1);
    reg_is("R2 slt signed false", 4, 0);
    reg_is("R2 sub", 5, 6);
    reg_is("R2 add wrap", 6, 4);
    reg_is("R3 r0 zero", 0, 0);
    reg_is("R4 addi negative imm", 9, 32'hFFFF_7FFF);
    reg_is("R1 reg after reset", 10, 0);

    // R8 freeze after halt
    repeat (5) @(negedge clk);
    chk("R8 pc held", pc, 32'd44);
    chk("R8 halted held", 32'(halted), 1);
    reg_is("R8 reg held", 5, 6);

    // R5 store and load
    clear_prog();
    b_mem[0] = enc_i(8, 0, 1, 'h800);
    b_mem[1] = enc_i(8, 0, 2, -7);
    b_mem[2] = enc_i('h2B, 1, 2, 4);
    b_mem[3] = enc_i('h23, 1, 3, 4);
    b_mem[4] = enc_i('h23, 1, 4, -4);
    b_mem[5] = enc_i('h23, 0, 5, 'h14);
    b_mem[6] = HALT;
    b_mem[20'h201] = 32'h0;
    b_mem[5'd5] = 32'hFFFF_FFFF;
    b_mem[6] = HALT;
    b_mem[5] = enc_i('h23, 0, 5, 'h18);
    run_prog("mem");
    reg_is("R5 load after store", 3, 32'hFFFF_FFF9);
    reg_is("R5 load program word", 5, HALT);

    // R6 branches
    clear_prog();
    b_mem[0] = enc_i(8, 0, 1, 3);
    b_mem[1] = enc_i(4, 1, 0, 5);
    b_mem[2] = enc_i(4, 0, 0, 2);
    b_mem[3] = HALT;
    b_mem[5] = enc_i(8, 0, 2, 1);
    b_mem[6] = enc_i(4, 1, 1, -4);
    b_mem[7] = HALT;
    run_prog("beq");
    reg_is("R6 taken target", 2, 1);
    chk("R6 backward pc", pc, 32'd12);

    // R7 jump
    clear_prog();
    b_mem[0] = enc_j(10);
    b_mem[10] = enc_i(8, 0, 4, 77);
    b_mem[11] = HALT;
    run_prog("jump");
    reg_is("R7 jump landing", 4, 77);
    chk("R7 pc", pc, 32'd44);

    // R9 misaligned
    clear_prog();
    b_mem[0] = enc_i(8, 0, 1, 2);
    b_mem[1] = enc_i('h23, 1, 3, 0);
    b_mem[2] = HALT;
    run_prog("mis_lw");
    chk("R9 cause misaligned", 32'(cause), 1);
    chk("R9 pc frozen", pc, 32'd4);
    clear_prog();
    b_mem[0] = enc_i(8, 0, 1, 'h801);
    b_mem[1] = enc_i('h2B, 1, 1, 3);
    b_mem[2] = enc_i('h23, 0, 2, 'h804);
    b_mem[3] = HALT;
    run_prog("mis_sw");

    // R10 out of range: data high, data negative, fetch
    clear_prog();
    b_mem[0] = enc_i(8, 0, 1, 'h1000);
    b_mem[1] = enc_i('h2B, 1, 1, 0);
    b_mem[2] = HALT;
    run_prog("oob_sw");
    chk("R10 cause range", 32'(cause), 2);
    clear_prog();
    b_mem[0] = enc_i('h23, 0, 1, -4);
    b_mem[1] = HALT;
    run_prog("oob_neg");
    clear_prog();
    b_mem[0] = enc_j('h400);
    run_prog("oob_fetch");
    chk("R10 fetch range", 32'(cause), 2);

    // R11 illegal
    clear_prog();
    b_mem[0] = enc_i(8, 0, 1, 1);
    b_mem[1] = 32'hFC00_0000;
    run_prog("ill_op");
    chk("R11 cause illegal", 32'(cause), 3);
    clear_prog();
    b_mem[0] = enc_r(0, 0, 1, 'h21);
    run_prog("ill_fn");

    // R1 preload ignored while running
    clear_prog();
    b_mem[0] = enc_j(0);
    preload();
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    load_en = 1'b1; load_addr = 10'd0; load_data = HALT;
    repeat (3) @(negedge clk);
    load_en = 1'b0;
    repeat (10) @(negedge clk);
    chk("R1 preload ignored halted", 32'(halted), 0);
    chk("R1 preload ignored pc", pc, 0);

    // random legal programs
    for (int t = 0; t < 10; t++) begin
      clear_prog();
      for (int i = 0; i < 30; i++) begin
        int k;
        k = int'($urandom_range(0, 9));
        case (k)
          0, 1: b_mem[i] = enc_i(8, $urandom_range(0, 7), $urandom_range(0, 7), $urandom_range(0, 65535));
          2: b_mem[i] = enc_i('h2B, 0, $urandom_range(0, 7), 'h800 + 4 * $urandom_range(0, 15));
          3: b_mem[i] = enc_i('h23, 0, $urandom_range(0, 7), 'h800 + 4 * $urandom_range(0, 15));
          4: b_mem[i] = enc_i(4, $urandom_range(0, 3), $urandom_range(0, 3), $urandom_range(0, 3));
          default: begin
            int f;
            f = int'($urandom_range(0, 4));
            b_mem[i] = enc_r($urandom_range(0, 7), $urandom_range(0, 7), $urandom_range(0, 7),
                             f == 0 ? 'h20 : f == 1 ? 'h22 : f == 2 ? 'h24 : f == 3 ? 'h25 : 'h2A);
          end
        endcase
      end
      for (int i = 30; i < 34; i++) b_mem[i] = HALT;
      run_prog("random R2 R4 R5 R6");
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule